// File: doc/BRIEF.md
# Ethernet PHY Basic Control and Status Registers

This block holds the two basic management registers of a 10/100 Ethernet PHY. Address 0 is a 16-bit control word. Its fields drive the PHY's configuration outputs: loopback, speed, auto-negotiation enable, low-power mode, data-path isolation, auto-negotiation restart, duplex and collision test. Address 1 is a read-only status word. It reports the PHY's fixed abilities, which are set by parameters, together with live and latched event state. The event state comes from the link, remote-fault, jabber and auto-negotiation logic elsewhere in the PHY.

A management front end decodes serial frames and presents each register access to the block as a one-cycle strobe. Read data is combinational from the address. A read strobe on the status address returns the value present before the clock edge. At that same edge the latched event bits are re-evaluated from the current event inputs.

Which control bits can be written, and what they reset to, depends on the ability parameters. A PHY with a single speed, a single duplex mode or no auto-negotiation has the matching field tied to the only legal value.

Top module: `phy_basic_regs`

## Requirements
- R1: After the hardware reset, or a cycle with the synchronous `soft_rst` high, every control field returns to its default and the latched status bits are cleared. Loopback, low power, isolate, restart and collision test default to 0. Auto-negotiation enable defaults to its ability. Speed defaults to 1 unless the PHY has only 10 Mb/s abilities. Duplex defaults to 1 only for a PHY with only full-duplex abilities.
- R2: The control word at address 0 places its fields as follows: bit 14 loopback, bit 13 speed (1 = 100 Mb/s), bit 12 auto-negotiation enable, bit 11 low power, bit 10 isolate, bit 9 restart, bit 8 duplex (1 = full) and bit 7 collision test. Bits 6:0 always read 0. A write updates the fields, and each field drives its output pin.
- R3: When the PHY supports exactly one speed, bit 13 always reads as that speed and writes to it are ignored.
- R4: When the PHY supports exactly one duplex mode, bit 8 always reads as that mode and writes to it are ignored.
- R5: Without auto-negotiation ability, bit 12 reads 0 and a written 1 is ignored.
- R6: Restart can be set only by a write that has bit 9 at 1 and bit 12 at 1, on a PHY able to auto-negotiate. It then reads 1 until `restart_ack_i` is seen, after which it clears. Writing 0 to bit 9 does not clear it. Disabling auto-negotiation clears it.
- R7: The status word at address 1 reports the ability parameters: bit 15 100BASE-T4, bit 14 100BASE-X full duplex, bit 13 100BASE-X half duplex, bit 12 10 Mb/s full duplex, bit 11 10 Mb/s half duplex, bit 6 preamble suppression, bit 3 auto-negotiation ability and bit 0 extended registers. Bits 10:7 read 0, and writes to address 1 have no effect.
- R8: Link status (bit 2) latches low. One cycle with `link_up_i` low clears it, and it stays 0 until a status read. After that read it follows the live link level at the read.
- R9: Remote fault (bit 4) and jabber (bit 1) latch high. An event cycle sets them, and a status read reloads them from the event inputs at that read. A PHY with no 10 Mb/s ability always returns 0 for jabber.
- R10: Auto-negotiation complete (bit 5) shows `aneg_done_i` only while auto-negotiation is enabled and supported. Otherwise it reads 0.
- R11: Reads of any address other than 0 and 1 return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous reset that reloads all defaults |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rd | input | 1 | Read strobe (clears latches on address 1) |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| link_up_i | input | 1 | Live link-valid level |
| rfault_evt_i | input | 1 | Remote-fault event |
| jabber_evt_i | input | 1 | Jabber event |
| aneg_done_i | input | 1 | Auto-negotiation complete from the engine |
| restart_ack_i | input | 1 | Engine has begun a restart |
| loopback_o | output | 1 | Loopback field |
| speed100_o | output | 1 | Speed field, 1 = 100 Mb/s |
| aneg_en_o | output | 1 | Auto-negotiation enable field |
| pwr_down_o | output | 1 | Low-power field |
| isolate_o | output | 1 | Isolate field |
| restart_o | output | 1 | Pending auto-negotiation restart |
| full_dplx_o | output | 1 | Duplex field, 1 = full |
| col_test_o | output | 1 | Collision-test field |

## Verification
Most wrong state in this block shows up on the next read. A control field that is mis-stored, or a tied field that accepts a write, is visible on its output pin one cycle after the write and in the next read of address 0. A latch with the wrong policy is visible only at the reads around an event. Examples are a link bit that recovers without a read, or a fault bit that survives its clearing read. The bench therefore reads the status word twice after each event pulse. The restart bit depends on a sequence of writes and acknowledge, so it is checked after each of those steps. A second instance with restricted abilities exposes any field that should be tied but is not.

// File: rtl/phy_regs_pkg.sv
package phy_regs_pkg;

   localparam int REG_W = 16;

   // control word positions
   localparam int C_LOOP = 14;
   localparam int C_SPD  = 13;
   localparam int C_ANEN = 12;
   localparam int C_PDN  = 11;
   localparam int C_ISO  = 10;
   localparam int C_RST  = 9;
   localparam int C_DPX  = 8;
   localparam int C_COL  = 7;

   // status word positions
   localparam int S_T4  = 15;
   localparam int S_XFD = 14;
   localparam int S_XHD = 13;
   localparam int S_TFD = 12;
   localparam int S_THD = 11;
   localparam int S_PRE = 6;
   localparam int S_ANC = 5;
   localparam int S_RF  = 4;
   localparam int S_ANA = 3;
   localparam int S_LNK = 2;
   localparam int S_JAB = 1;
   localparam int S_EXT = 0;

   typedef struct packed {
      logic loop;
      logic spd;
      logic anen;
      logic pdn;
      logic iso;
      logic rst;
      logic dpx;
      logic col;
   } ctl_fields_t;

   function automatic ctl_fields_t ctl_default(bit has100, bit hasfull,
                                               bit hashalf, bit aneg);
      ctl_fields_t d;
      d      = '0;
      d.spd  = has100;
      d.dpx  = hasfull && !hashalf;
      d.anen = aneg;
      return d;
   endfunction

   function automatic logic [REG_W-1:0] ctl_pack(ctl_fields_t f);
      logic [REG_W-1:0] w;
      w         = '0;
      w[C_LOOP] = f.loop;
      w[C_SPD]  = f.spd;
      w[C_ANEN] = f.anen;
      w[C_PDN]  = f.pdn;
      w[C_ISO]  = f.iso;
      w[C_RST]  = f.rst;
      w[C_DPX]  = f.dpx;
      w[C_COL]  = f.col;
      return w;
   endfunction

endpackage

// File: rtl/phy_cfg_bit.sv
module phy_cfg_bit #(
   parameter bit FIXED = 1'b0,
   parameter bit DEFV  = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic wr_en,
   input  logic wbit,
   output logic q_o
);
   generate
      if (FIXED) begin : g_tied
         logic unused_in;
         assign unused_in = ^{clk, rst_n, soft_rst, wr_en, wbit};
         assign q_o = DEFV;
      end else begin : g_rw
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= DEFV;
            else if (soft_rst) q <= DEFV;
            else if (wr_en)    q <= wbit;
         end
         assign q_o = q;
      end
   endgenerate
endmodule

// File: rtl/phy_evt_latch.sv
module phy_evt_latch #(
   parameter bit LATCH_LOW = 1'b0,
   parameter bit PRESENT   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic rd_clr,
   input  logic evt_i,
   output logic q_o
);
   generate
      if (!PRESENT) begin : g_absent
         logic unused_in;
         assign unused_in = ^{clk, rst_n, soft_rst, rd_clr, evt_i};
         assign q_o = 1'b0;
      end else begin : g_present
         logic q;
         logic hold;
         // a read reloads from the live input; otherwise keep the sticky value
         if (LATCH_LOW) begin : g_low
            assign hold = q & evt_i;
         end else begin : g_high
            assign hold = q | evt_i;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= 1'b0;
            else if (soft_rst) q <= 1'b0;
            else if (rd_clr)   q <= evt_i;
            else               q <= hold;
         end
         assign q_o = q;
      end
   endgenerate
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
   import phy_regs_pkg::*;
#(
   parameter bit ABLE_100  = 1'b1,
   parameter bit ABLE_10   = 1'b1,
   parameter bit ABLE_FULL = 1'b1,
   parameter bit ABLE_HALF = 1'b1,
   parameter bit ABLE_ANEG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   input  logic             restart_ack_i,
   output ctl_fields_t      fld_o
);
   localparam bit SPD_FIX = (ABLE_100 != ABLE_10);
   localparam bit DPX_FIX = (ABLE_FULL != ABLE_HALF);
   localparam ctl_fields_t DEF = ctl_default(ABLE_100, ABLE_FULL, ABLE_HALF, ABLE_ANEG);

   logic unused_low;
   assign unused_low = ^wdata[C_COL-1:0] ^ wdata[REG_W-1];

   phy_cfg_bit #(.FIXED(1'b0), .DEFV(DEF.loop)) u_loop (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
      .wbit(wdata[C_LOOP]), .q_o(fld_o.loop));
   phy_cfg_bit #(.FIXED(SPD_FIX), .DEFV(DEF.spd)) u_spd (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
      .wbit(wdata[C_SPD]), .q_o(fld_o.spd));
   phy_cfg_bit #(.FIXED(!ABLE_ANEG), .DEFV(DEF.anen)) u_anen (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
      .wbit(wdata[C_ANEN]), .q_o(fld_o.anen));
   phy_cfg_bit #(.FIXED(1'b0), .DEFV(DEF.pdn)) u_pdn (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
      .wbit(wdata[C_PDN]), .q_o(fld_o.pdn));
   phy_cfg_bit #(.FIXED(1'b0), .DEFV(DEF.iso)) u_iso (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
      .wbit(wdata[C_ISO]), .q_o(fld_o.iso));
   phy_cfg_bit #(.FIXED(DPX_FIX), .DEFV(DEF.dpx)) u_dpx (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
      .wbit(wdata[C_DPX]), .q_o(fld_o.dpx));
   phy_cfg_bit #(.FIXED(1'b0), .DEFV(DEF.col)) u_col (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
      .wbit(wdata[C_COL]), .q_o(fld_o.col));

   generate
      if (ABLE_ANEG) begin : g_restart
         logic rst_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          rst_q <= 1'b0;
            else if (soft_rst)                   rst_q <= 1'b0;
            else if (wr_en && !wdata[C_ANEN])    rst_q <= 1'b0;
            else if (wr_en && wdata[C_RST])      rst_q <= 1'b1;
            else if (restart_ack_i)              rst_q <= 1'b0;
         end
         assign fld_o.rst = rst_q;
      end else begin : g_no_restart
         logic unused_ack;
         assign unused_ack = restart_ack_i;
         assign fld_o.rst = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/phy_stat_reg.sv
module phy_stat_reg
   import phy_regs_pkg::*;
#(
   parameter bit ABLE_T4   = 1'b0,
   parameter bit ABLE_X_FD = 1'b1,
   parameter bit ABLE_X_HD = 1'b1,
   parameter bit ABLE_T_FD = 1'b1,
   parameter bit ABLE_T_HD = 1'b1,
   parameter bit ABLE_ANEG = 1'b1,
   parameter bit PRE_SUPP  = 1'b1,
   parameter bit EXT_REGS  = 1'b0,
   parameter bit RFAULT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             rd_clr,
   input  logic             link_up_i,
   input  logic             rfault_evt_i,
   input  logic             jabber_evt_i,
   input  logic             aneg_done_i,
   input  logic             anen_i,
   output logic [REG_W-1:0] word_o,
   output logic             link_q_o,
   output logic             rf_q_o,
   output logic             jab_q_o
);
   localparam bit HAS_10 = ABLE_T_FD | ABLE_T_HD;

   phy_evt_latch #(.LATCH_LOW(1'b1), .PRESENT(1'b1)) u_link (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rd_clr(rd_clr),
      .evt_i(link_up_i), .q_o(link_q_o));
   phy_evt_latch #(.LATCH_LOW(1'b0), .PRESENT(RFAULT_EN)) u_rf (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rd_clr(rd_clr),
      .evt_i(rfault_evt_i), .q_o(rf_q_o));
   phy_evt_latch #(.LATCH_LOW(1'b0), .PRESENT(HAS_10)) u_jab (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rd_clr(rd_clr),
      .evt_i(jabber_evt_i), .q_o(jab_q_o));

   always_comb begin
      word_o        = '0;
      word_o[S_T4]  = ABLE_T4;
      word_o[S_XFD] = ABLE_X_FD;
      word_o[S_XHD] = ABLE_X_HD;
      word_o[S_TFD] = ABLE_T_FD;
      word_o[S_THD] = ABLE_T_HD;
      word_o[S_PRE] = PRE_SUPP;
      word_o[S_ANC] = ABLE_ANEG & anen_i & aneg_done_i;
      word_o[S_RF]  = rf_q_o;
      word_o[S_ANA] = ABLE_ANEG;
      word_o[S_LNK] = link_q_o;
      word_o[S_JAB] = jab_q_o;
      word_o[S_EXT] = EXT_REGS;
   end
endmodule

// File: rtl/phy_basic_regs.sv
module phy_basic_regs
   import phy_regs_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int DATA_W    = 16,
   parameter bit ABLE_T4   = 1'b0,
   parameter bit ABLE_X_FD = 1'b1,
   parameter bit ABLE_X_HD = 1'b1,
   parameter bit ABLE_T_FD = 1'b1,
   parameter bit ABLE_T_HD = 1'b1,
   parameter bit ABLE_ANEG = 1'b1,
   parameter bit PRE_SUPP  = 1'b1,
   parameter bit EXT_REGS  = 1'b0,
   parameter bit RFAULT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_rd,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              link_up_i,
   input  logic              rfault_evt_i,
   input  logic              jabber_evt_i,
   input  logic              aneg_done_i,
   input  logic              restart_ack_i,
   output logic              loopback_o,
   output logic              speed100_o,
   output logic              aneg_en_o,
   output logic              pwr_down_o,
   output logic              isolate_o,
   output logic              restart_o,
   output logic              full_dplx_o,
   output logic              col_test_o
);
   localparam bit HAS_100  = ABLE_T4 | ABLE_X_FD | ABLE_X_HD;
   localparam bit HAS_10   = ABLE_T_FD | ABLE_T_HD;
   localparam bit HAS_FULL = ABLE_X_FD | ABLE_T_FD;
   localparam bit HAS_HALF = ABLE_T4 | ABLE_X_HD | ABLE_T_HD;
   localparam logic [ADDR_W-1:0] CTL_ADDR  = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1);

   generate
      if (DATA_W != REG_W) begin : g_bad_width
         $error("phy_basic_regs: DATA_W must be 16");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("phy_basic_regs: ADDR_W must be at least 1");
      end
      if (!(HAS_100 || HAS_10)) begin : g_no_ability
         $error("phy_basic_regs: at least one ability is required");
      end
   endgenerate

   logic             ctl_wr;
   logic             stat_rd;
   ctl_fields_t      fld;
   logic [REG_W-1:0] stat_word;
   logic             link_q;
   logic             rf_q;
   logic             jab_q;

   assign ctl_wr  = reg_wr && (reg_addr == CTL_ADDR);
   assign stat_rd = reg_rd && (reg_addr == STAT_ADDR);

   phy_ctrl_reg #(
      .ABLE_100(HAS_100), .ABLE_10(HAS_10), .ABLE_FULL(HAS_FULL),
      .ABLE_HALF(HAS_HALF), .ABLE_ANEG(ABLE_ANEG)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(ctl_wr),
      .wdata(reg_wdata[REG_W-1:0]), .restart_ack_i(restart_ack_i), .fld_o(fld));

   phy_stat_reg #(
      .ABLE_T4(ABLE_T4), .ABLE_X_FD(ABLE_X_FD), .ABLE_X_HD(ABLE_X_HD),
      .ABLE_T_FD(ABLE_T_FD), .ABLE_T_HD(ABLE_T_HD), .ABLE_ANEG(ABLE_ANEG),
      .PRE_SUPP(PRE_SUPP), .EXT_REGS(EXT_REGS), .RFAULT_EN(RFAULT_EN)
   ) u_stat (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rd_clr(stat_rd),
      .link_up_i(link_up_i), .rfault_evt_i(rfault_evt_i),
      .jabber_evt_i(jabber_evt_i), .aneg_done_i(aneg_done_i),
      .anen_i(fld.anen), .word_o(stat_word),
      .link_q_o(link_q), .rf_q_o(rf_q), .jab_q_o(jab_q));

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == CTL_ADDR)       reg_rdata = DATA_W'(ctl_pack(fld));
      else if (reg_addr == STAT_ADDR) reg_rdata = DATA_W'(stat_word);
   end

   assign loopback_o  = fld.loop;
   assign speed100_o  = fld.spd;
   assign aneg_en_o   = fld.anen;
   assign pwr_down_o  = fld.pdn;
   assign isolate_o   = fld.iso;
   assign restart_o   = fld.rst;
   assign full_dplx_o = fld.dpx;
   assign col_test_o  = fld.col;
endmodule

// File: rtl/phy_basic_regs_chk.sv
module phy_basic_regs_chk
   import phy_regs_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 16,
   parameter bit HAS_100  = 1'b1,
   parameter bit HAS_10   = 1'b1,
   parameter bit HAS_FULL = 1'b1,
   parameter bit HAS_HALF = 1'b1,
   parameter bit ABLE_ANEG = 1'b1,
   parameter bit RFAULT_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              soft_rst,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              link_up_i,
   input logic              rfault_evt_i,
   input logic              restart_ack_i,
   input logic [7:0]        ctl_pins,
   input logic              link_q,
   input logic              rf_q,
   input logic              jab_q
);
   localparam ctl_fields_t DEF = ctl_default(HAS_100, HAS_FULL, HAS_HALF, ABLE_ANEG);
   localparam logic [7:0] DEF_PINS = DEF;

   logic ctl_wr;
   logic stat_rd;
   ctl_fields_t pins;
   assign ctl_wr  = reg_wr && (reg_addr == ADDR_W'(0));
   assign stat_rd = reg_rd && (reg_addr == ADDR_W'(1));
   assign pins    = ctl_pins;

   // R1
   soft_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (ctl_pins == DEF_PINS));

   // R2
   ctl_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(0)) |-> (reg_rdata[6:0] == 7'd0));

   // R5
   aneg_tied_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ABLE_ANEG |-> !pins.anen);

   // R6
   restart_needs_aneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pins.anen |-> !pins.rst);

   // R6
   restart_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pins.rst && restart_ack_i && !ctl_wr) |=> !pins.rst);

   // R8
   link_hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_up_i && !stat_rd) |=> !link_q);

   // R9
   rfault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (RFAULT_EN && rfault_evt_i && !soft_rst) |=> rf_q);

   // R9
   jabber_tied_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !HAS_10 |-> !jab_q);
endmodule

bind phy_basic_regs phy_basic_regs_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .HAS_100(HAS_100), .HAS_10(HAS_10), .HAS_FULL(HAS_FULL), .HAS_HALF(HAS_HALF),
   .ABLE_ANEG(ABLE_ANEG), .RFAULT_EN(RFAULT_EN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_addr(reg_addr),
   .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
   .link_up_i(link_up_i), .rfault_evt_i(rfault_evt_i),
   .restart_ack_i(restart_ack_i),
   .ctl_pins({loopback_o, speed100_o, aneg_en_o, pwr_down_o, isolate_o,
              restart_o, full_dplx_o, col_test_o}),
   .link_q(link_q), .rf_q(rf_q), .jab_q(jab_q)
);

// File: tb/phy_basic_regs_tb.sv
module phy_basic_regs_tb;

   typedef struct {
      int          sel;
      logic [15:0] exp;
      string       tag;
   } rd_item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic soft_rst = 1'b0;
   int   checks = 0;
   int   failures = 0;
   rd_item_t exp_q[$];

   always #10 clk = ~clk;

   // main instance: default abilities
   logic [4:0]  m_addr = '0;
   logic        m_wr = 1'b0, m_rd = 1'b0;
   logic [15:0] m_wdata = '0, m_rdata;
   logic        m_link = 1'b0, m_rf = 1'b0, m_jab = 1'b0, m_done = 1'b0, m_ack = 1'b0;
   logic        m_loop, m_spd, m_anen, m_pdn, m_iso, m_rst, m_dpx, m_col;

   // restricted instance: 100BASE-X half duplex only, no auto-negotiation
   logic [4:0]  l_addr = '0;
   logic        l_wr = 1'b0, l_rd = 1'b0;
   logic [15:0] l_wdata = '0, l_rdata;
   logic        l_link = 1'b1, l_jab = 1'b0, l_done = 1'b0;
   logic        l_loop, l_spd, l_anen, l_pdn, l_iso, l_rst, l_dpx, l_col;

   phy_basic_regs u_dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .reg_addr(m_addr), .reg_wr(m_wr), .reg_wdata(m_wdata), .reg_rd(m_rd),
      .reg_rdata(m_rdata), .link_up_i(m_link), .rfault_evt_i(m_rf),
      .jabber_evt_i(m_jab), .aneg_done_i(m_done), .restart_ack_i(m_ack),
      .loopback_o(m_loop), .speed100_o(m_spd), .aneg_en_o(m_anen),
      .pwr_down_o(m_pdn), .isolate_o(m_iso), .restart_o(m_rst),
      .full_dplx_o(m_dpx), .col_test_o(m_col));

   phy_basic_regs #(
      .ABLE_T4(1'b0), .ABLE_X_FD(1'b0), .ABLE_X_HD(1'b1),
      .ABLE_T_FD(1'b0), .ABLE_T_HD(1'b0), .ABLE_ANEG(1'b0)
   ) u_dut_lim (
      .clk(clk), .rst_n(rst_n), .soft_rst(1'b0),
      .reg_addr(l_addr), .reg_wr(l_wr), .reg_wdata(l_wdata), .reg_rd(l_rd),
      .reg_rdata(l_rdata), .link_up_i(l_link), .rfault_evt_i(1'b0),
      .jabber_evt_i(l_jab), .aneg_done_i(l_done), .restart_ack_i(1'b0),
      .loopback_o(l_loop), .speed100_o(l_spd), .aneg_en_o(l_anen),
      .pwr_down_o(l_pdn), .isolate_o(l_iso), .restart_o(l_rst),
      .full_dplx_o(l_dpx), .col_test_o(l_col));

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   task automatic check_val(logic [15:0] got, logic [15:0] exp, string tag);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
      end
   endtask

   // driver: one-cycle read, expectation pushed to scoreboard
   task automatic rd(int sel, logic [4:0] a, logic [15:0] exp, string tag);
      rd_item_t it;
      @(negedge clk);
      it.sel = sel; it.exp = exp; it.tag = tag;
      exp_q.push_back(it);
      if (sel == 0) begin m_addr = a; m_rd = 1'b1; end
      else          begin l_addr = a; l_rd = 1'b1; end
      @(negedge clk);
      m_rd = 1'b0; l_rd = 1'b0;
   endtask

   task automatic wr(int sel, logic [4:0] a, logic [15:0] d);
      @(negedge clk);
      if (sel == 0) begin m_addr = a; m_wdata = d; m_wr = 1'b1; end
      else          begin l_addr = a; l_wdata = d; l_wr = 1'b1; end
      @(negedge clk);
      m_wr = 1'b0; l_wr = 1'b0;
   endtask

   // monitor: compares read data in the middle of the low phase
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if ((m_rd || l_rd) && exp_q.size() > 0) begin
            rd_item_t it;
            it = exp_q.pop_front();
            check_val((it.sel == 0) ? m_rdata : l_rdata, it.exp, it.tag);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset defaults (main and restricted)
      rd(0, 5'd0, 16'h3000, "R1 main ctrl default");
      rd(0, 5'd1, 16'h7848, "R7 main status after reset");
      rd(1, 5'd0, 16'h2000, "R1 R3 R4 lim ctrl default");
      rd(1, 5'd1, 16'h2040, "R7 lim status link latched");
      rd(1, 5'd1, 16'h2044, "R8 lim link after read");

      // R8 latch-low link
      m_link = 1'b1;
      rd(0, 5'd1, 16'h7848, "R8 link still low before read");
      rd(0, 5'd1, 16'h784C, "R8 link follows after read");
      @(negedge clk); m_link = 1'b0;
      @(negedge clk); m_link = 1'b1;
      rd(0, 5'd1, 16'h7848, "R8 glitch held low");
      rd(0, 5'd1, 16'h784C, "R8 link recovered on read");

      // R9 latch-high fault and jabber
      @(negedge clk); m_rf = 1'b1;
      @(negedge clk); m_rf = 1'b0;
      rd(0, 5'd1, 16'h785C, "R9 remote fault latched");
      rd(0, 5'd1, 16'h784C, "R9 remote fault cleared by read");
      @(negedge clk); m_jab = 1'b1;
      @(negedge clk); m_jab = 1'b0;
      rd(0, 5'd1, 16'h784E, "R9 jabber latched");
      rd(0, 5'd1, 16'h784C, "R9 jabber cleared by read");

      // R2 field positions and pins
      wr(0, 5'd0, 16'h7CFF);
      rd(0, 5'd0, 16'h7C80, "R2 ctrl write low bits zero");
      @(negedge clk);
      check_val({8'h0, m_loop, m_spd, m_anen, m_pdn, m_iso, m_rst, m_dpx, m_col},
                16'h00F9, "R2 ctrl pins");

      // R6 restart
      wr(0, 5'd0, 16'h7E80);
      rd(0, 5'd0, 16'h7E80, "R6 restart set");
      check_val({15'h0, m_rst}, 16'h0001, "R6 restart pin set");
      wr(0, 5'd0, 16'h7C80);
      rd(0, 5'd0, 16'h7E80, "R6 write zero keeps restart");
      @(negedge clk); m_ack = 1'b1;
      @(negedge clk); m_ack = 1'b0;
      rd(0, 5'd0, 16'h7C80, "R6 restart cleared by ack");

      // R10 auto-negotiation complete gating
      m_done = 1'b1;
      rd(0, 5'd1, 16'h786C, "R10 complete shown when enabled");
      wr(0, 5'd0, 16'h2000);
      rd(0, 5'd1, 16'h784C, "R10 complete hidden when disabled");
      wr(0, 5'd0, 16'h0200);
      rd(0, 5'd0, 16'h0000, "R6 restart ignored when disabled");
      check_val({15'h0, m_rst}, 16'h0000, "R6 restart pin stays low");

      // R2/R4 writable speed and duplex on full-ability instance
      wr(0, 5'd0, 16'h2100);
      rd(0, 5'd0, 16'h2100, "R2 duplex writable");
      check_val({15'h0, m_dpx}, 16'h0001, "R2 duplex pin");

      // R7 status write ignored, R11 unmapped
      wr(0, 5'd1, 16'hFFFF);
      rd(0, 5'd1, 16'h784C, "R7 status write ignored");
      wr(0, 5'd5, 16'hFFFF);
      rd(0, 5'd5, 16'h0000, "R11 unmapped reads zero");
      rd(0, 5'd0, 16'h2100, "R11 ctrl untouched by unmapped write");

      // R1 soft reset
      @(negedge clk); m_jab = 1'b1;
      @(negedge clk); m_jab = 1'b0;
      @(negedge clk); soft_rst = 1'b1;
      @(negedge clk); soft_rst = 1'b0;
      rd(0, 5'd0, 16'h3000, "R1 soft reset ctrl");
      rd(0, 5'd1, 16'h7868, "R1 soft reset clears latches");

      // R3 R4 R5 R9 tied fields on restricted instance
      wr(1, 5'd0, 16'hFFFF);
      rd(1, 5'd0, 16'h6C80, "R3 R5 tied fields ignore ones");
      check_val({14'h0, l_anen, l_rst}, 16'h0000, "R5 lim aneg and restart pins");
      wr(1, 5'd0, 16'h0100);
      rd(1, 5'd0, 16'h2000, "R3 R4 tied speed and duplex");
      @(negedge clk); l_jab = 1'b1; l_done = 1'b1;
      @(negedge clk); l_jab = 1'b0;
      rd(1, 5'd1, 16'h2044, "R9 R10 no jabber no complete on lim");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         failures++;
         $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
      end
      summary();
      $finish;
   end
endmodule